// File: doc/BRIEF.md
# Flash Command Controller

This block sits between a parallel host bus and the write engine of a two-partition NOR-style flash device. The host issues commands by writing an 8-bit code on the low data byte. Some commands take one bus cycle and some take two. The controller selects what a read returns: the array, the status byte, the configuration space or the query space. It collects two-cycle program, erase, configuration and lock sequences and passes each complete sequence to the write engine as a one-cycle start pulse. The pulse carries an operation code, the address and the data of the second write.

Each partition keeps its own status byte, and the most significant address bit selects the partition. While the engine runs, every read returns the status of the partition being written, and the controller acts only on status-read and suspend commands. A suspend holds the engine paused until a resume command arrives. All bus strobes are active low and are sampled on the rising clock edge. One bus cycle lasts one clock.

The states are ST_IDLE, ST_PGM_SETUP, ST_ERS_SETUP, ST_CFG_SETUP, ST_LOCK_SETUP, ST_BUSY and ST_SUSP, with these transitions:
- From ST_IDLE, a write of 40h or 10h goes to ST_PGM_SETUP, 20h goes to ST_ERS_SETUP, 60h goes to ST_CFG_SETUP and C0h goes to ST_LOCK_SETUP.
- From any of the four setup states, the next write goes to ST_BUSY and starts the engine. The exception is ST_ERS_SETUP: there, any byte other than D0h goes back to ST_IDLE and sets the sequence error bit.
- ST_BUSY goes to ST_IDLE when the engine reports ready, except in the start cycle. It goes to ST_SUSP on B0h.
- ST_SUSP goes back to ST_BUSY on D0h.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the controller is in array read mode (rd_src = 0), a read returns ext_rdata, eng_start and eng_suspend are low, and partition 0 status reads 0080h.
- R2: A write is taken only when ce_n = 0, we_n = 0, oe_n = 1 and bus_rst_n = 1. A read takes place only when ce_n = 0, oe_n = 0, we_n = 1 and bus_rst_n = 1. At all other times dout is 0 and dout_en is low.
- R3: When idle or suspended, write FFh to select array reads (rd_src 0), 70h for status (1), 90h for configuration (2) and 98h for query (3). In array, configuration and query modes a read returns ext_rdata.
- R4: In status mode, partition addr[AW-1] of the 70h write is read back. dout[15:8] is 0, bit 7 is ready, bit 6 is suspended and bit 5 is sequence error. All other bits are 0.
- R5: A write of 40h or 10h followed by a second write gives a one-cycle eng_start on the clock after the second write. It carries eng_op = 0 and the address and data of that second write. Reads then return the status of that write's partition.
- R6: A write of 20h followed by D0h starts the engine with eng_op = 1 and the address of the D0h write.
- R7: A write of 20h followed by any byte other than D0h sets the sequence error bit of the partition addressed by the second write. The engine does not start, and the controller moves to status mode on that partition.
- R8: A write of 60h or C0h followed by a second write starts the engine with eng_op = 2 or 3 respectively.
- R9: While busy, status bit 7 reads 0 and every read returns the status of the active partition. Writes other than 70h and B0h have no effect.
- R10: A B0h write while busy raises eng_suspend on the next clock and sets the suspended bit. Status bit 7 then reads 1. A D0h write clears both and returns to busy.
- R11: A 50h write clears the sequence error bits of both partitions and leaves the ready and suspended bits unchanged.
- R12: Busy ends on the first clock on which eng_ready is high that is not the start cycle. The full command set is then accepted again. The engine must drop eng_ready on the clock after it sees eng_start.
- R13: In the idle state, codes with no assigned meaning, and B0h and D0h, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_rst_n | input | 1 | Bus reset strobe; must be high for any bus cycle |
| addr | input | AW | Word address; the top bit selects the partition |
| din | input | DW | Write data; the command code is din[7:0] |
| ext_rdata | input | DW | Array, configuration or query data supplied from outside |
| dout | output | DW | Read data |
| dout_en | output | 1 | High during a read cycle |
| rd_src | output | 2 | Current read source: 0 array, 1 status, 2 configuration, 3 query |
| eng_ready | input | 1 | Write engine idle |
| eng_start | output | 1 | One-cycle start request |
| eng_op | output | 2 | Operation: 0 program, 1 erase, 2 configuration, 3 lock |
| eng_addr | output | AW | Target address of the operation |
| eng_data | output | DW | Data of the operation |
| eng_suspend | output | 1 | Pause request to the write engine |

## Verification
The assertions check on every cycle the properties that hold at each clock. The start pulse lasts a single cycle and always follows a qualified write, and an erase start always follows a D0h write. The bus stays quiet outside read cycles, and the status byte has a zero upper half. While busy, the read source is status with the ready bit clear, and suspend never coincides with busy. The properties that depend on history need the bench's scenarios to show them. These include the partition selection by address, the routing of sequence errors, the clear that spares the ready and suspend bits, and commands ignored during a busy period whose effect would appear only after it ends. The bench's scenarios also show the pause and resume of the engine across a suspend.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CW = 8;

    localparam logic [CW-1:0] CODE_PGM     = 8'h40;
    localparam logic [CW-1:0] CODE_PGM_ALT = 8'h10;
    localparam logic [CW-1:0] CODE_ERASE   = 8'h20;
    localparam logic [CW-1:0] CODE_CLEAR   = 8'h50;
    localparam logic [CW-1:0] CODE_CFG     = 8'h60;
    localparam logic [CW-1:0] CODE_RD_SR   = 8'h70;
    localparam logic [CW-1:0] CODE_RD_CFG  = 8'h90;
    localparam logic [CW-1:0] CODE_RD_QRY  = 8'h98;
    localparam logic [CW-1:0] CODE_SUSPEND = 8'hB0;
    localparam logic [CW-1:0] CODE_LOCK    = 8'hC0;
    localparam logic [CW-1:0] CODE_CONFIRM = 8'hD0;
    localparam logic [CW-1:0] CODE_RD_ARR  = 8'hFF;

    localparam int SR_READY  = 7;
    localparam int SR_SUSP   = 6;
    localparam int SR_SEQERR = 5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PGM_SETUP, ST_ERS_SETUP, ST_CFG_SETUP,
        ST_LOCK_SETUP, ST_BUSY, ST_SUSP
    } fsm_state_t;

    typedef enum logic [1:0] {
        RD_ARRAY, RD_STATUS, RD_CONFIG, RD_QUERY
    } rd_src_t;

    typedef enum logic [1:0] {
        OP_PROGRAM, OP_ERASE, OP_CONFIG, OP_LOCK
    } eng_op_t;

    typedef enum logic [3:0] {
        K_NONE, K_PGM, K_ERS, K_CLR, K_CFG, K_RDSR, K_RDCFG,
        K_RDQRY, K_SUSP, K_LOCK, K_CONF, K_RDARR
    } cmd_kind_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [CW-1:0] code,
    output cmd_kind_t     kind
);
    always_comb begin
        case (code)
            CODE_PGM, CODE_PGM_ALT: kind = K_PGM;
            CODE_ERASE:             kind = K_ERS;
            CODE_CLEAR:             kind = K_CLR;
            CODE_CFG:               kind = K_CFG;
            CODE_RD_SR:             kind = K_RDSR;
            CODE_RD_CFG:            kind = K_RDCFG;
            CODE_RD_QRY:            kind = K_RDQRY;
            CODE_SUSPEND:           kind = K_SUSP;
            CODE_LOCK:              kind = K_LOCK;
            CODE_CONFIRM:           kind = K_CONF;
            CODE_RD_ARR:            kind = K_RDARR;
            default:                kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/flash_status_regs.sv
module flash_status_regs
    import flash_cmd_pkg::*;
#(
    parameter int NPART = 2,
    parameter int PBITS = 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             busy,
    input  logic             clr_err,
    input  logic             set_err,
    input  logic [PBITS-1:0] err_part,
    input  logic             set_susp,
    input  logic             clr_susp,
    input  logic [PBITS-1:0] susp_part,
    input  logic [PBITS-1:0] rd_part,
    output logic [CW-1:0]    sr_rd
);
    logic [NPART-1:0] err_q;
    logic [NPART-1:0] susp_q;
    logic [CW-1:0]    sr_all [NPART];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            err_q  <= '0;
            susp_q <= '0;
        end else begin
            for (int p = 0; p < NPART; p++) begin
                if (clr_err)
                    err_q[p] <= 1'b0;
                else if (set_err && err_part == PBITS'(p))
                    err_q[p] <= 1'b1;
                if (set_susp && susp_part == PBITS'(p))
                    susp_q[p] <= 1'b1;
                else if (clr_susp && susp_part == PBITS'(p))
                    susp_q[p] <= 1'b0;
            end
        end
    end

    for (genvar g = 0; g < NPART; g++) begin : g_part
        always_comb begin
            sr_all[g]            = '0;
            sr_all[g][SR_READY]  = !busy;
            sr_all[g][SR_SUSP]   = susp_q[g];
            sr_all[g][SR_SEQERR] = err_q[g];
        end
    end

    assign sr_rd = sr_all[rd_part];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 21,
    parameter int DW    = 16,
    parameter int PBITS = 1
) (
    input  logic             clk,
    input  logic             arst_n,
    input  logic             wr_cyc,
    input  cmd_kind_t        kind,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    input  logic             eng_ready,
    output rd_src_t          rd_src,
    output logic [PBITS-1:0] stat_part,
    output logic             busy,
    output logic             eng_start,
    output eng_op_t          eng_op,
    output logic [AW-1:0]    eng_addr,
    output logic [DW-1:0]    eng_data,
    output logic             eng_suspend,
    output logic             set_err,
    output logic             clr_err,
    output logic             set_susp,
    output logic             clr_susp,
    output logic [PBITS-1:0] act_part,
    output logic [PBITS-1:0] wr_part
);
    fsm_state_t       state, state_d;
    rd_src_t          rd_q;
    logic [PBITS-1:0] spart_q;
    logic             go;
    eng_op_t          go_op;
    logic             mode_wr;

    assign wr_part = addr[AW-1 -: PBITS];
    assign busy    = (state == ST_BUSY);
    assign mode_wr = wr_cyc && (state == ST_IDLE || state == ST_SUSP);

    // state register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state <= ST_IDLE;
        else         state <= state_d;
    end

    // next state and sequence decisions
    always_comb begin
        state_d  = state;
        go       = 1'b0;
        go_op    = OP_PROGRAM;
        set_err  = 1'b0;
        clr_err  = 1'b0;
        set_susp = 1'b0;
        clr_susp = 1'b0;
        unique case (state)
            ST_IDLE: if (wr_cyc) begin
                case (kind)
                    K_PGM:   state_d = ST_PGM_SETUP;
                    K_ERS:   state_d = ST_ERS_SETUP;
                    K_CFG:   state_d = ST_CFG_SETUP;
                    K_LOCK:  state_d = ST_LOCK_SETUP;
                    K_CLR:   clr_err = 1'b1;
                    default: ;
                endcase
            end
            ST_PGM_SETUP: if (wr_cyc) begin
                go = 1'b1; go_op = OP_PROGRAM; state_d = ST_BUSY;
            end
            ST_CFG_SETUP: if (wr_cyc) begin
                go = 1'b1; go_op = OP_CONFIG; state_d = ST_BUSY;
            end
            ST_LOCK_SETUP: if (wr_cyc) begin
                go = 1'b1; go_op = OP_LOCK; state_d = ST_BUSY;
            end
            ST_ERS_SETUP: if (wr_cyc) begin
                if (kind == K_CONF) begin
                    go = 1'b1; go_op = OP_ERASE; state_d = ST_BUSY;
                end else begin
                    set_err = 1'b1; state_d = ST_IDLE;
                end
            end
            ST_BUSY: begin
                if (wr_cyc && kind == K_SUSP) begin
                    set_susp = 1'b1; state_d = ST_SUSP;
                end else if (eng_ready && !eng_start) begin
                    state_d = ST_IDLE;
                end
            end
            ST_SUSP: if (wr_cyc) begin
                case (kind)
                    K_CONF:  begin clr_susp = 1'b1; state_d = ST_BUSY; end
                    K_CLR:   clr_err = 1'b1;
                    default: ;
                endcase
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            rd_q        <= RD_ARRAY;
            spart_q     <= '0;
            act_part    <= '0;
            eng_start   <= 1'b0;
            eng_op      <= OP_PROGRAM;
            eng_addr    <= '0;
            eng_data    <= '0;
            eng_suspend <= 1'b0;
        end else begin
            eng_start   <= go;
            eng_suspend <= (state_d == ST_SUSP);
            if (go) begin
                eng_op   <= go_op;
                eng_addr <= addr;
                eng_data <= din;
                act_part <= wr_part;
                rd_q     <= RD_STATUS;
                spart_q  <= wr_part;
            end else if (set_err) begin
                rd_q    <= RD_STATUS;
                spart_q <= wr_part;
            end else if (mode_wr) begin
                case (kind)
                    K_RDARR: rd_q <= RD_ARRAY;
                    K_RDSR:  begin rd_q <= RD_STATUS; spart_q <= wr_part; end
                    K_RDCFG: rd_q <= RD_CONFIG;
                    K_RDQRY: rd_q <= RD_QUERY;
                    default: ;
                endcase
            end
        end
    end

    assign rd_src    = busy ? RD_STATUS : rd_q;
    assign stat_part = busy ? act_part  : spart_q;
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int AW    = 21,
    parameter int DW    = 16,
    parameter int NPART = 2
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          bus_rst_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] ext_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    output logic [1:0]    rd_src,
    input  logic          eng_ready,
    output logic          eng_start,
    output logic [1:0]    eng_op,
    output logic [AW-1:0] eng_addr,
    output logic [DW-1:0] eng_data,
    output logic          eng_suspend
);
    localparam int PBITS = $clog2(NPART);

    logic             wr_cyc, rd_cyc;
    cmd_kind_t        kind;
    rd_src_t          rd_src_e;
    eng_op_t          eng_op_e;
    logic [PBITS-1:0] stat_part, act_part, wr_part;
    logic             busy, set_err, clr_err, set_susp, clr_susp;
    logic [CW-1:0]    sr_rd;

    assign wr_cyc = !ce_n && !we_n && oe_n && bus_rst_n;
    assign rd_cyc = !ce_n && !oe_n && we_n && bus_rst_n;

    flash_cmd_decode u_dec (
        .code (din[CW-1:0]),
        .kind (kind)
    );

    flash_cmd_fsm #(.AW(AW), .DW(DW), .PBITS(PBITS)) u_fsm (
        .clk         (clk),
        .arst_n      (arst_n),
        .wr_cyc      (wr_cyc),
        .kind        (kind),
        .addr        (addr),
        .din         (din),
        .eng_ready   (eng_ready),
        .rd_src      (rd_src_e),
        .stat_part   (stat_part),
        .busy        (busy),
        .eng_start   (eng_start),
        .eng_op      (eng_op_e),
        .eng_addr    (eng_addr),
        .eng_data    (eng_data),
        .eng_suspend (eng_suspend),
        .set_err     (set_err),
        .clr_err     (clr_err),
        .set_susp    (set_susp),
        .clr_susp    (clr_susp),
        .act_part    (act_part),
        .wr_part     (wr_part)
    );

    flash_status_regs #(.NPART(NPART), .PBITS(PBITS)) u_sr (
        .clk       (clk),
        .arst_n    (arst_n),
        .busy      (busy),
        .clr_err   (clr_err),
        .set_err   (set_err),
        .err_part  (wr_part),
        .set_susp  (set_susp),
        .clr_susp  (clr_susp),
        .susp_part (act_part),
        .rd_part   (stat_part),
        .sr_rd     (sr_rd)
    );

    assign rd_src  = rd_src_e;
    assign eng_op  = eng_op_e;
    assign dout_en = rd_cyc;

    always_comb begin
        if (!rd_cyc)
            dout = '0;
        else if (rd_src_e == RD_STATUS)
            dout = {{(DW-CW){1'b0}}, sr_rd};
        else
            dout = ext_rdata;
    end
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          arst_n,
    input logic          ce_n,
    input logic          we_n,
    input logic          oe_n,
    input logic          bus_rst_n,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic          dout_en,
    input logic [1:0]    rd_src,
    input logic          eng_start,
    input logic [1:0]    eng_op,
    input logic          eng_suspend,
    input logic          busy
);
    logic wr_seen;
    logic rd_ok;
    assign wr_seen = !ce_n && !we_n && oe_n && bus_rst_n;
    assign rd_ok   = !ce_n && !oe_n && we_n && bus_rst_n;

    a_r5_start_pulse: assert property (@(posedge clk) disable iff (!arst_n)
        eng_start |=> !eng_start);

    a_r5_start_after_write: assert property (@(posedge clk) disable iff (!arst_n)
        eng_start |-> $past(wr_seen));

    a_r6_erase_confirm: assert property (@(posedge clk) disable iff (!arst_n)
        (eng_start && eng_op == 2'd1) |-> $past(wr_seen && din[7:0] == 8'hD0));

    a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!arst_n)
        !rd_ok |-> (dout == '0 && !dout_en));

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (!arst_n)
        (dout_en && rd_src == 2'd1) |-> dout[DW-1:8] == '0);

    a_r9_busy_status: assert property (@(posedge clk) disable iff (!arst_n)
        busy |-> (rd_src == 2'd1 && !(dout_en && dout[7])));

    a_r9_start_busy: assert property (@(posedge clk) disable iff (!arst_n)
        eng_start |-> busy);

    a_r10_susp_not_busy: assert property (@(posedge clk) disable iff (!arst_n)
        eng_suspend |-> !busy);
endmodule

bind flash_cmd_ctrl flash_cmd_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .arst_n      (arst_n),
    .ce_n        (ce_n),
    .we_n        (we_n),
    .oe_n        (oe_n),
    .bus_rst_n   (bus_rst_n),
    .din         (din),
    .dout        (dout),
    .dout_en     (dout_en),
    .rd_src      (rd_src),
    .eng_start   (eng_start),
    .eng_op      (eng_op),
    .eng_suspend (eng_suspend),
    .busy        (busy)
);

// File: tb/sim_flash_cmd_ctrl.sv
module write_engine_stub #(parameter int DUR = 20) (
    input  logic clk,
    input  logic arst_n,
    input  logic start,
    input  logic suspend,
    output logic ready,
    output int   starts
);
    int cnt;
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ready <= 1'b1; cnt <= 0; starts <= 0;
        end else if (start) begin
            ready <= 1'b0; cnt <= DUR; starts <= starts + 1;
        end else if (!ready && !suspend) begin
            if (cnt == 0) ready <= 1'b1;
            else          cnt   <= cnt - 1;
        end
    end
endmodule

module sim_flash_cmd_ctrl;
    localparam int AW = 21;
    localparam int DW = 16;
    localparam logic [AW-1:0] P1 = 21'h100000;
    localparam logic [DW-1:0] XDATA = 16'h5A3C;

    logic clk = 0, arst_n = 0;
    logic ce_n = 1, we_n = 1, oe_n = 1, bus_rst_n = 1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_en, eng_ready, eng_start, eng_suspend;
    logic [1:0] rd_src, eng_op;
    logic [AW-1:0] eng_addr;
    logic [DW-1:0] eng_data;
    int starts;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    flash_cmd_ctrl #(.AW(AW), .DW(DW), .NPART(2)) u0 (
        .clk(clk), .arst_n(arst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .bus_rst_n(bus_rst_n), .addr(addr), .din(din), .ext_rdata(XDATA),
        .dout(dout), .dout_en(dout_en), .rd_src(rd_src), .eng_ready(eng_ready),
        .eng_start(eng_start), .eng_op(eng_op), .eng_addr(eng_addr),
        .eng_data(eng_data), .eng_suspend(eng_suspend)
    );

    write_engine_stub #(.DUR(20)) u_eng (
        .clk(clk), .arst_n(arst_n), .start(eng_start), .suspend(eng_suspend),
        .ready(eng_ready), .starts(starts)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        addr = a; din = d; ce_n = 0; we_n = 0;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0;
        #1 d = dout;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic idle_clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_ready();
        logic [DW-1:0] d;
        for (int i = 0; i < 200; i++) begin
            bus_read('0, d);
            if (d[7]) break;
        end
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R1 rd_src", rd_src, 0);
        chk("R1 eng_start", eng_start, 0);
        chk("R1 eng_suspend", eng_suspend, 0);
        bus_read('0, d);
        chk("R1 array read", d, XDATA);
        bus_write('0, 16'h0070);
        bus_read('0, d);
        chk("R1 status p0", d, 16'h0080);
    endtask

    task automatic t_qualify();
        logic [DW-1:0] d;
        bus_write('0, 16'h00FF);
        @(negedge clk); addr = '0; din = 16'h0070; ce_n = 0; we_n = 0; oe_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1; oe_n = 1;
        chk("R2 write with oe low ignored", rd_src, 0);
        @(negedge clk); din = 16'h0070; ce_n = 0; we_n = 0; bus_rst_n = 0;
        @(negedge clk); ce_n = 1; we_n = 1; bus_rst_n = 1;
        chk("R2 write with bus reset ignored", rd_src, 0);
        @(negedge clk); oe_n = 0; ce_n = 1;
        #1 chk("R2 no read without ce", {dout_en, dout}, 0);
        oe_n = 1;
        bus_read('0, d);
        chk("R2 qualified read", d, XDATA);
    endtask

    task automatic t_read_modes();
        logic [DW-1:0] d;
        bus_write('0, 16'h0090);
        chk("R3 config mode", rd_src, 2);
        bus_read('0, d);
        chk("R3 config read", d, XDATA);
        bus_write('0, 16'h0098);
        chk("R3 query mode", rd_src, 3);
        bus_write(P1, 16'h0070);
        chk("R3 status mode", rd_src, 1);
        bus_read('0, d);
        chk("R4 status p1 upper zero", d, 16'h0080);
        bus_write('0, 16'h00FF);
        chk("R3 array mode", rd_src, 0);
    endtask

    task automatic t_program();
        int s0 = starts;
        bus_write('0, 16'h0040);
        bus_write(21'h000123, 16'hBEEF);
        chk("R5 start pulse", eng_start, 1);
        chk("R5 op", eng_op, 0);
        chk("R5 addr", eng_addr, 21'h000123);
        chk("R5 data", eng_data, 16'hBEEF);
        @(negedge clk);
        chk("R5 pulse one cycle", eng_start, 0);
        wait_ready();
        bus_write('0, 16'h0010);
        bus_write(P1 | 21'h7, 16'h1111);
        chk("R5 alt code op", {eng_start, eng_op}, {1'b1, 2'd0});
        wait_ready();
        chk("R12 two starts", starts - s0, 2);
    endtask

    task automatic t_erase();
        bus_write(P1, 16'h0020);
        bus_write(P1 | 21'h40, 16'h00D0);
        chk("R6 erase start", {eng_start, eng_op}, {1'b1, 2'd1});
        chk("R6 erase addr", eng_addr, P1 | 21'h40);
        wait_ready();
    endtask

    task automatic t_erase_bad();
        logic [DW-1:0] d;
        int s0 = starts;
        bus_write('0, 16'h00FF);
        bus_write('0, 16'h0020);
        bus_write(21'h000040, 16'h00FF);
        chk("R7 no start", eng_start, 0);
        chk("R7 status mode", rd_src, 1);
        bus_read(P1, d);
        chk("R7 seq error p0", d, 16'h00A0);
        idle_clocks(3);
        chk("R7 engine untouched", starts - s0, 0);
    endtask

    task automatic t_cfg_lock();
        bus_write('0, 16'h0060);
        bus_write(21'h000005, 16'h0003);
        chk("R8 config op", {eng_start, eng_op}, {1'b1, 2'd2});
        wait_ready();
        bus_write('0, 16'h00C0);
        bus_write(21'h000080, 16'hFFFD);
        chk("R8 lock op", {eng_start, eng_op}, {1'b1, 2'd3});
        chk("R8 lock data", eng_data, 16'hFFFD);
        wait_ready();
    endtask

    task automatic t_busy();
        logic [DW-1:0] d;
        int s0 = starts;
        bus_write('0, 16'h0040);
        bus_write(P1 | 21'h10, 16'h1234);
        idle_clocks(2);
        bus_read('0, d);
        chk("R9 busy reads active partition", d, 16'h0000);
        chk("R9 rd_src status", rd_src, 1);
        bus_write('0, 16'h00FF);
        bus_write('0, 16'h0040);
        chk("R9 no start while busy", eng_start, 0);
        wait_ready();
        bus_read('0, d);
        chk("R12 ready after busy, writes ignored", d, 16'h0080);
        bus_write('0, 16'h0070);
        bus_read('0, d);
        chk("R9 p0 error kept", d, 16'h00A0);
        chk("R9 single start", starts - s0, 1);
    endtask

    task automatic t_clear();
        logic [DW-1:0] d;
        bus_write(P1, 16'h0020);
        bus_write(P1, 16'h0040);
        bus_read(P1, d);
        chk("R7 seq error p1", d, 16'h00A0);
        bus_write('0, 16'h0050);
        bus_read('0, d);
        chk("R11 p1 cleared", d, 16'h0080);
        bus_write('0, 16'h0070);
        bus_read('0, d);
        chk("R11 p0 cleared", d, 16'h0080);
    endtask

    task automatic t_suspend();
        logic [DW-1:0] d;
        int s0 = starts;
        bus_write('0, 16'h0040);
        bus_write(21'h000200, 16'h00AA);
        idle_clocks(3);
        bus_write('0, 16'h00B0);
        chk("R10 suspend raised", eng_suspend, 1);
        bus_read('0, d);
        chk("R10 suspended status", d, 16'h00C0);
        idle_clocks(40);
        chk("R10 engine held", eng_ready, 0);
        bus_write('0, 16'h0050);
        bus_read('0, d);
        chk("R11 clear keeps suspend", d, 16'h00C0);
        bus_write('0, 16'h00D0);
        chk("R10 suspend dropped", eng_suspend, 0);
        bus_read('0, d);
        chk("R10 resumed busy", d, 16'h0000);
        wait_ready();
        bus_read('0, d);
        chk("R10 done clean", d, 16'h0080);
        chk("R10 no restart", starts - s0, 1);
    endtask

    task automatic t_ignore();
        logic [DW-1:0] d;
        int s0 = starts;
        bus_write('0, 16'h00FF);
        bus_write('0, 16'h0033);
        bus_write('0, 16'h00B0);
        bus_write('0, 16'h00D0);
        bus_read('0, d);
        chk("R13 still array", d, XDATA);
        chk("R13 no suspend", eng_suspend, 0);
        bus_write('0, 16'h0040);
        bus_write(21'h000009, 16'h0009);
        chk("R13 idle kept", eng_start, 1);
        wait_ready();
        chk("R13 one start", starts - s0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        arst_n = 1;
        @(negedge clk);
        t_reset();
        t_qualify();
        t_read_modes();
        t_program();
        t_erase();
        t_erase_bad();
        t_cfg_lock();
        t_busy();
        t_clear();
        t_suspend();
        t_ignore();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule